// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by fetching page table entries from memory. A requester hands it a 32-bit virtual address together with the byte address of the root (first-level) table. The walker reads the first-level entry. If that entry is valid, it takes the frame number the entry holds as the base of a second-level table and reads the leaf entry from there. It then hands the leaf entry, the virtual page number and the resulting physical address back to the requester, which writes them into the translation cache.

Either entry may be invalid. In that case the walk stops at that level and reports a page fault instead of a fill. All memory traffic goes over one word-wide request/response port with valid/ready handshakes on both directions, and the response may arrive after any number of cycles. Only one miss is serviced at a time. A busy flag is high from the moment a miss is accepted until its result has been taken.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy is 0, miss_ready is 1, and mem_req_valid, mem_rsp_ready and done_valid are all 0.
- R2: The first read goes to address root + vaddr[31:22]*4.
- R3: The second read goes to address (L1 frame << 12) + vaddr[21:12]*4. The L1 frame is bits 31:12 of the first-level entry.
- R4: In every entry, bit 0 is the valid bit and bits 31:12 hold the frame number. On a successful walk, done_valid rises with the following values:
  - done_fault = 0
  - done_pte = the second-level entry
  - done_vpn = vaddr[31:12]
  - done_paddr = (leaf frame << 12) | vaddr[11:0]. For example, vaddr 0x01005a6f with a leaf frame of 0xe gives 0xea6f.
- R5: If the first-level entry has bit 0 clear, the walk reports done_fault = 1 and done_level = 0, with done_pte holding that entry. No second read is issued.
- R6: If the second-level entry has bit 0 clear, the walk reports done_fault = 1, done_level = 1 and done_pte = that entry.
- R7: A read request, including its address, holds until mem_req_ready is seen. mem_rsp_ready is 1 while a response is awaited, whatever the latency.
- R8: The result and done_valid stay stable until done_ready is seen. In the following cycle busy and done_valid are 0.
- R9: busy is 1 from the cycle after a miss is accepted until its result is taken. While busy, miss_ready is 0 and a miss offered on the input is ignored, leaving the walk in progress unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A translation miss is offered |
| miss_ready | output | 1 | Walker idle and accepts a miss |
| miss_vaddr | input | 32 | Virtual address that missed |
| root_base | input | 32 | Byte address of the first-level table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker accepts read data |
| mem_rsp_data | input | 32 | Entry read from memory |
| done_valid | output | 1 | Walk result valid |
| done_ready | input | 1 | Requester takes the result |
| done_fault | output | 1 | 1 = page fault, 0 = fill the cache |
| done_level | output | 1 | Faulting level, 0 = first, 1 = second |
| done_vpn | output | 20 | Virtual page number of the walk |
| done_pte | output | 32 | Leaf entry, or the faulting entry |
| done_paddr | output | 32 | Translated physical address |

## Verification
A corrupted stored frame or index would show up at the second memory request, since that address would be wrong. The fault would therefore appear at the port one request before any result, and the bench compares every request address. A wrong validity decision would show up as a second request that should not have been issued, or as a fault or fill of the wrong kind. That error becomes visible in the cycle after the first response. A state machine that drops a handshake would either hang or release its result early, and the bench catches this with back-pressure and varied response latency on every walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_L1_REQ  = 3'd1,
        ST_L1_WAIT = 3'd2,
        ST_L2_REQ  = 3'd3,
        ST_L2_WAIT = 3'd4,
        ST_DONE    = 3'd5
    } walk_state_e;

endpackage

// File: rtl/ptw_index.sv
module ptw_index #(
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int IDX_W   = 10,
    parameter int AW      = 32,
    parameter int ENT_SH  = 2
) (
    input  logic [VA_W-1:0]     vaddr,
    input  logic [AW-1:0]       root,
    input  logic [AW-1:0]       base2,
    input  logic [AW-OFF_W-1:0] leaf_frame,
    output logic [AW-1:0]       l1_addr,
    output logic [AW-1:0]       l2_addr,
    output logic [VA_W-OFF_W-1:0] vpn,
    output logic [AW-1:0]       paddr
);
    localparam int PAD_W = AW - IDX_W - ENT_SH;

    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] mid_idx;
    logic [OFF_W-1:0] offset;

    always_comb begin
        top_idx = vaddr[VA_W-1 -: IDX_W];
        mid_idx = vaddr[OFF_W +: IDX_W];
        offset  = vaddr[OFF_W-1:0];
        vpn     = vaddr[VA_W-1:OFF_W];
        l1_addr = root  + {{PAD_W{1'b0}}, top_idx, {ENT_SH{1'b0}}};
        l2_addr = base2 + {{PAD_W{1'b0}}, mid_idx, {ENT_SH{1'b0}}};
        paddr   = {leaf_frame, offset};
    end
endmodule

// File: rtl/ptw_entry.sv
module ptw_entry #(
    parameter int AW    = 32,
    parameter int OFF_W = 12
) (
    input  logic [AW-OFF_W-1:0] frame,
    input  logic                vbit,
    output logic [AW-1:0]       base,
    output logic                valid
);
    always_comb begin
        base  = {frame, {OFF_W{1'b0}}};
        valid = vbit;
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import pt_walker_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 10,
    parameter int PTE_W     = 32,
    parameter int VALID_BIT = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  miss_valid,
    output logic                  miss_ready,
    input  logic [VA_W-1:0]       miss_vaddr,
    input  logic [PTE_W-1:0]      root_base,
    output logic                  busy,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [PTE_W-1:0]      mem_req_addr,
    input  logic                  mem_rsp_valid,
    output logic                  mem_rsp_ready,
    input  logic [PTE_W-1:0]      mem_rsp_data,
    output logic                  done_valid,
    input  logic                  done_ready,
    output logic                  done_fault,
    output logic                  done_level,
    output logic [VA_W-OFF_W-1:0] done_vpn,
    output logic [PTE_W-1:0]      done_pte,
    output logic [PTE_W-1:0]      done_paddr
);
    localparam int AW     = PTE_W;
    localparam int ENT_SH = $clog2(PTE_W / 8);

    typedef struct packed {
        walk_state_e      state;
        logic [VA_W-1:0]  vaddr;
        logic [AW-1:0]    root;
        logic [AW-1:0]    base2;
        logic [PTE_W-1:0] pte;
        logic             fault;
        logic             level;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [AW-1:0] l1_addr;
    logic [AW-1:0] l2_addr;
    logic [AW-1:0] rsp_base;
    logic          rsp_ok;

    ptw_index #(
        .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .AW(AW), .ENT_SH(ENT_SH)
    ) u_index (
        .vaddr      (r_q.vaddr),
        .root       (r_q.root),
        .base2      (r_q.base2),
        .leaf_frame (r_q.pte[PTE_W-1:OFF_W]),
        .l1_addr    (l1_addr),
        .l2_addr    (l2_addr),
        .vpn        (done_vpn),
        .paddr      (done_paddr)
    );

    ptw_entry #(.AW(AW), .OFF_W(OFF_W)) u_rsp_entry (
        .frame (mem_rsp_data[PTE_W-1:OFF_W]),
        .vbit  (mem_rsp_data[VALID_BIT]),
        .base  (rsp_base),
        .valid (rsp_ok)
    );

    always_comb begin
        r_d           = r_q;
        miss_ready    = 1'b0;
        mem_req_valid = 1'b0;
        mem_rsp_ready = 1'b0;
        done_valid    = 1'b0;
        mem_req_addr  = (r_q.state == ST_L1_REQ) ? l1_addr : l2_addr;

        case (r_q.state)
            ST_IDLE: begin
                miss_ready = 1'b1;
                if (miss_valid) begin
                    r_d.vaddr = miss_vaddr;
                    r_d.root  = root_base;
                    r_d.fault = 1'b0;
                    r_d.level = 1'b0;
                    r_d.state = ST_L1_REQ;
                end
            end
            ST_L1_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) r_d.state = ST_L1_WAIT;
            end
            ST_L1_WAIT: begin
                mem_rsp_ready = 1'b1;
                if (mem_rsp_valid) begin
                    r_d.pte = mem_rsp_data;
                    if (rsp_ok) begin
                        r_d.base2 = rsp_base;
                        r_d.state = ST_L2_REQ;
                    end else begin
                        r_d.fault = 1'b1;
                        r_d.level = 1'b0;
                        r_d.state = ST_DONE;
                    end
                end
            end
            ST_L2_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) r_d.state = ST_L2_WAIT;
            end
            ST_L2_WAIT: begin
                mem_rsp_ready = 1'b1;
                if (mem_rsp_valid) begin
                    r_d.pte   = mem_rsp_data;
                    r_d.fault = ~rsp_ok;
                    r_d.level = 1'b1;
                    r_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                done_valid = 1'b1;
                if (done_ready) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy       = (r_q.state != ST_IDLE);
    assign done_fault = r_q.fault;
    assign done_level = r_q.level;
    assign done_pte   = r_q.pte;

    // R7: a pending request keeps valid and address until taken
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R8: the result holds until the requester takes it
    a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && !done_ready |=> done_valid && $stable(done_pte)
                                      && $stable(done_fault) && $stable(done_paddr));

    // R9: no new miss is accepted during a walk
    a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !miss_ready);

    // R5: an invalid first-level entry ends the walk with a fault, no second read
    a_r5_l1_fault: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_ready && mem_rsp_valid && !rsp_ok && !mem_req_valid && (r_q.state == ST_L1_WAIT)
        |=> done_valid && done_fault && !done_level);

    // R1: at most one handshake role is active in any cycle
    a_r1_one_role: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({miss_ready, mem_req_valid, mem_rsp_ready, done_valid}));
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int VA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 10,
    parameter int PTE_W     = 32,
    parameter int VALID_BIT = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  miss_valid,
    output logic                  miss_ready,
    input  logic [VA_W-1:0]       miss_vaddr,
    input  logic [PTE_W-1:0]      root_base,
    output logic                  busy,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [PTE_W-1:0]      mem_req_addr,
    input  logic                  mem_rsp_valid,
    output logic                  mem_rsp_ready,
    input  logic [PTE_W-1:0]      mem_rsp_data,
    output logic                  done_valid,
    input  logic                  done_ready,
    output logic                  done_fault,
    output logic                  done_level,
    output logic [VA_W-OFF_W-1:0] done_vpn,
    output logic [PTE_W-1:0]      done_pte,
    output logic [PTE_W-1:0]      done_paddr
);
    ptw_ctrl #(
        .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
        .PTE_W(PTE_W), .VALID_BIT(VALID_BIT)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .miss_ready    (miss_ready),
        .miss_vaddr    (miss_vaddr),
        .root_base     (root_base),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_ready (mem_rsp_ready),
        .mem_rsp_data  (mem_rsp_data),
        .done_valid    (done_valid),
        .done_ready    (done_ready),
        .done_fault    (done_fault),
        .done_level    (done_level),
        .done_vpn      (done_vpn),
        .done_pte      (done_pte),
        .done_paddr    (done_paddr)
    );
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
    localparam logic [31:0] ROOT = 32'h0010_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss_valid = 1'b0;
    logic miss_ready;
    logic [31:0] miss_vaddr = '0;
    logic [31:0] root_base = ROOT;
    logic busy;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic mem_rsp_ready;
    logic [31:0] mem_rsp_data = '0;
    logic done_valid;
    logic done_ready = 1'b0;
    logic done_fault;
    logic done_level;
    logic [19:0] done_vpn;
    logic [31:0] done_pte;
    logic [31:0] done_paddr;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pt_walker dut_i (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit l1_bad(input int i);
        return (i % 5) == 3;
    endfunction

    function automatic bit l2_bad(input int i, input int j);
        return ((i + j) % 7) == 3;
    endfunction

    function automatic logic [31:0] leaf_frame(input int i, input int j);
        return ((i ^ j) + 13) & 32'h000f_ffff;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        int i;
        int j;
        if (a >= ROOT && a < ROOT + 32'd4096) begin
            i = int'((a - ROOT) >> 2);
            return ((32'h200 + i) << 12) | 32'h100 | (l1_bad(i) ? 32'd0 : 32'd1);
        end else if (a[31:12] >= 20'h200 && a[31:12] < 20'h600) begin
            i = int'(a[31:12]) - 32'h200;
            j = int'(a[11:2]);
            return (leaf_frame(i, j) << 12) | (j << 1) | (l2_bad(i, j) ? 32'd0 : 32'd1);
        end
        return 32'hdead_0000;
    endfunction

    task automatic walk(input logic [31:0] va, input int lat, input int stall,
                        input bit meddle);
        int i;
        int j;
        bit f1;
        bit f2;
        logic [31:0] exp_addr [2];
        logic [31:0] exp_pte;
        int n;
        i = int'(va >> 22);
        j = int'((va >> 12) & 32'h3ff);
        f1 = l1_bad(i);
        f2 = l2_bad(i, j);
        exp_addr[0] = ROOT + (va >> 22) * 4;
        exp_addr[1] = ((32'h200 + i) << 12) + ((va >> 12) & 32'h3ff) * 4;
        exp_pte = f1 ? mem_word(exp_addr[0]) : mem_word(exp_addr[1]);

        @(negedge clk);
        check(miss_ready == 1'b1, "R9 idle miss_ready", {31'd0, miss_ready}, 32'd1);
        miss_valid = 1'b1;
        miss_vaddr = va;
        @(negedge clk);
        miss_valid = 1'b0;
        check(busy == 1'b1, "R9 busy after accept", {31'd0, busy}, 32'd1);

        for (int lv = 0; lv < 2; lv++) begin
            n = 0;
            while (!mem_req_valid && n < 50) begin
                @(negedge clk);
                n++;
            end
            repeat (stall) @(negedge clk);
            check(mem_req_valid && mem_req_addr == exp_addr[lv],
                  lv == 0 ? "R2 first read address" : "R3 second read address",
                  mem_req_addr, exp_addr[lv]);
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            if (meddle && lv == 0) begin
                miss_valid = 1'b1;
                miss_vaddr = ~va;
                check(miss_ready == 1'b0, "R9 miss refused while busy",
                      {31'd0, miss_ready}, 32'd0);
                @(negedge clk);
                miss_valid = 1'b0;
            end
            repeat (lat) @(negedge clk);
            check(mem_rsp_ready == 1'b1, "R7 response awaited",
                  {31'd0, mem_rsp_ready}, 32'd1);
            mem_rsp_valid = 1'b1;
            mem_rsp_data = mem_word(exp_addr[lv]);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (lv == 0 && f1) begin
                check(mem_req_valid == 1'b0, "R5 no second read",
                      {31'd0, mem_req_valid}, 32'd0);
                break;
            end
        end

        n = 0;
        while (!done_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        if (f1) begin
            check(done_valid && done_fault && !done_level, "R5 first-level fault",
                  {30'd0, done_fault, done_level}, 32'd2);
            check(done_pte == exp_pte, "R5 faulting entry", done_pte, exp_pte);
        end else if (f2) begin
            check(done_valid && done_fault && done_level, "R6 second-level fault",
                  {30'd0, done_fault, done_level}, 32'd3);
            check(done_pte == exp_pte, "R6 faulting entry", done_pte, exp_pte);
        end else begin
            check(done_valid && !done_fault, "R4 fill flag", {31'd0, done_fault}, 32'd0);
            check(done_pte == exp_pte, "R4 leaf entry", done_pte, exp_pte);
            check(done_vpn == va[31:12], "R4 vpn", {12'd0, done_vpn}, {12'd0, va[31:12]});
            check(done_paddr == ((leaf_frame(i, j) << 12) | (va & 32'hfff)), "R4 paddr",
                  done_paddr, (leaf_frame(i, j) << 12) | (va & 32'hfff));
        end
        @(negedge clk);
        check(done_valid && done_pte == exp_pte, "R8 result held", done_pte, exp_pte);
        done_ready = 1'b1;
        @(negedge clk);
        done_ready = 1'b0;
        check(!busy && !done_valid, "R8 idle after take",
              {30'd0, busy, done_valid}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && miss_ready && !mem_req_valid && !mem_rsp_ready && !done_valid,
              "R1 reset outputs",
              {27'd0, busy, miss_ready, mem_req_valid, mem_rsp_ready, done_valid},
              32'h08);
        rst_n = 1'b1;

        // R4 worked example: index 4 / 5, leaf frame 0xe
        walk(32'h0100_5a6f, 1, 0, 1'b0);
        check(done_paddr == 32'h0000_ea6f, "R4 example paddr", done_paddr, 32'h0000_ea6f);

        for (int i = 0; i < 1024; i++) begin
            walk({i[9:0], 10'((i * 13) % 1024), 12'((i * 77) % 4096)},
                 i % 4, i % 3, (i % 4) == 1);
        end
        for (int j = 0; j < 64; j++) begin
            walk({10'd7, j[9:0], 12'hfff - 12'(j)}, (j + 1) % 4, j % 2, 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule